// File: doc/BRIEF.md
# Accumulator ALU with BCD adjust

This block is the arithmetic and logic unit beside an 8-bit accumulator. A sequencer presents an operation code together with the current accumulator, a second operand, the B register and the three status flags: carry, auxiliary (nibble) carry and overflow. It pulses `start`, and the block returns the new accumulator, operand and B values and the updated flags on registered outputs.

Most operations finish in one clock. Multiply and divide run as eight-step shift loops. `busy` stays high while one of them runs and `done` marks its completion. The caller fetches operands and writes the results back to its register file; the block keeps no architectural state of its own beyond the last result it presented.

The output registers hold their values until the next accepted operation completes. `done` is a one-cycle pulse.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, every output is driven to zero after that edge, including `busy` and `done`.
- R2: Code 0 (add) and code 1 (add with carry) set `acc_out` to the 8-bit sum of A, the operand and, for code 1 only, `cy_in`. Carry is the carry out of bit 7 and auxiliary carry is the carry out of bit 3. Overflow is set when the signed result leaves -128..127.
- R3: Code 2 (subtract with borrow) sets `acc_out` to A minus the operand minus `cy_in`. Carry flags a borrow from bit 7 and auxiliary carry a borrow from bit 3. Overflow is the borrow into bit 7 XOR the borrow out of it.
- R4: Code 3 increments A and code 4 decrements A. Both wrap between 0xFF and 0x00 and pass all three flags through unchanged.
- R5: Codes 5, 6 and 7 give the bitwise AND, OR and XOR of A and the operand. Code 8 inverts A and code 9 clears it. All five pass the flags through.
- R6: Code 10 rotates A left and code 12 rotates it right, both within the byte with carry unchanged. Code 11 rotates left through carry and code 13 rotates right through carry: the bit shifted out goes to carry and the old carry fills the vacated bit.
- R7: Code 14 swaps the two nibbles of A. Code 15 exchanges the low nibble of A with the low nibble of the operand and returns the new operand on `opnd_out`. Both keep the high nibbles and the flags.
- R8: Code 16 (decimal adjust) first adds 0x06 if A[3:0] > 9 or `ac_in` is set. It then adds 0x60 if the high nibble of the intermediate value is above 9 or carry is set. Carry is set if either addition carries out and is never cleared; auxiliary carry and overflow pass through.
- R9: Code 17 (multiply) puts the low product byte in `acc_out` and the high byte in `b_out`. It clears carry, sets overflow exactly when the high byte is nonzero, and passes auxiliary carry through.
- R10: Code 18 (divide) puts the quotient in `acc_out` and the remainder in `b_out` and clears carry and overflow. With B equal to zero, A and B are returned unchanged, overflow is set and `done` still arrives on time.
- R11: An operation is accepted when `start` is high and `busy` is low. A single-cycle operation updates the outputs and raises `done` for one cycle right after the accepting edge, and copies `b_in` to `b_out`. Multiply and divide raise `busy` after the accepting edge, keep `opnd_out` unchanged, and finish 9 edges later with `done` high and `busy` low. A `start` seen while `busy` is high is ignored.
- R12: Codes 19 to 31 copy A, the operand, B and the flags to the outputs unchanged and raise `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to run `op` on the presented values |
| op | input | 5 | Operation code (see requirements) |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Second operand |
| b_in | input | 8 | Current B register |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary carry flag |
| ov_in | input | 1 | Current overflow flag |
| acc_out | output | 8 | New accumulator |
| opnd_out | output | 8 | New operand value (changes only for digit exchange) |
| b_out | output | 8 | New B register |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary carry flag |
| ov_out | output | 1 | New overflow flag |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | One-cycle pulse when results are valid |

## Verification
The bench goes after the flag edges of the arithmetic. 0x7F+1 and 0x80-1 must raise overflow without carry, and a design that took overflow from carry alone would miss both. 0x00-1 with a borrow pending must set every borrow flag. The decimal-adjust cases cover an adjust that comes only from the auxiliary carry, an adjust that comes only from an incoming carry (0x99 becomes 0xF9), and 0x9A, where the second addition creates the carry; a single-step adjust, or one that clears a carry already set, returns the wrong byte or carry. Multiply by 0xFF squared and divide by zero check the high byte, the overflow rule and the unchanged A/B return. A `start` issued mid-multiply checks that a design that accepted it does not corrupt the pending result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW  = 8;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,  OP_INC  = 5'd3,
    OP_DEC  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_CPL  = 5'd8,  OP_CLR  = 5'd9,  OP_RL   = 5'd10, OP_RLC  = 5'd11,
    OP_RR   = 5'd12, OP_RRC  = 5'd13, OP_SWAP = 5'd14, OP_XCHD = 5'd15,
    OP_DA   = 5'd16, OP_MUL  = 5'd17, OP_DIV  = 5'd18
  } alu_op_e;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  o,
  input  logic           cy_i,
  input  logic           ac_i,
  input  logic           ov_i,
  output logic [DW-1:0]  res,
  output logic           cy_o,
  output logic           ac_o,
  output logic           ov_o,
  output logic           hit
);
  logic       cin;
  logic [4:0] add_lo, sub_lo;
  logic [7:0] add_mid, sub_mid;
  logic [8:0] add_full, sub_full;
  logic       da_lo_fix, da_hi_fix, da_c1, da_c2;
  logic [8:0] da_t1, da_t2;

  assign cin      = (op == OP_ADDC || op == OP_SUBB) ? cy_i : 1'b0;
  assign add_lo   = {1'b0, a[3:0]} + {1'b0, o[3:0]} + {4'd0, cin};
  assign add_mid  = {1'b0, a[6:0]} + {1'b0, o[6:0]} + {7'd0, cin};
  assign add_full = {1'b0, a} + {1'b0, o} + {8'd0, cin};
  assign sub_lo   = {1'b0, a[3:0]} - {1'b0, o[3:0]} - {4'd0, cin};
  assign sub_mid  = {1'b0, a[6:0]} - {1'b0, o[6:0]} - {7'd0, cin};
  assign sub_full = {1'b0, a} - {1'b0, o} - {8'd0, cin};

  // two-step decimal correction
  assign da_lo_fix = (a[3:0] > 4'd9) || ac_i;
  assign da_t1     = {1'b0, a} + (da_lo_fix ? 9'h006 : 9'h000);
  assign da_c1     = cy_i | da_t1[8];
  assign da_hi_fix = (da_t1[7:4] > 4'd9) || da_c1;
  assign da_t2     = {1'b0, da_t1[7:0]} + (da_hi_fix ? 9'h060 : 9'h000);
  assign da_c2     = da_c1 | da_t2[8];

  always_comb begin
    res  = a;
    cy_o = cy_i;
    ac_o = ac_i;
    ov_o = ov_i;
    hit  = 1'b1;
    case (op)
      OP_ADD, OP_ADDC: begin
        res  = add_full[7:0];
        cy_o = add_full[8];
        ac_o = add_lo[4];
        ov_o = add_mid[7] ^ add_full[8];
      end
      OP_SUBB: begin
        res  = sub_full[7:0];
        cy_o = sub_full[8];
        ac_o = sub_lo[4];
        ov_o = sub_mid[7] ^ sub_full[8];
      end
      OP_DA: begin
        res  = da_t2[7:0];
        cy_o = da_c2;
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  o,
  input  logic           cy_i,
  output logic [DW-1:0]  res,
  output logic [DW-1:0]  opnd_res,
  output logic           cy_o,
  output logic           hit
);
  localparam int HN = DW / 2;

  always_comb begin
    res      = a;
    opnd_res = o;
    cy_o     = cy_i;
    hit      = 1'b1;
    case (op)
      OP_INC:  res = a + 1'b1;
      OP_DEC:  res = a - 1'b1;
      OP_AND:  res = a & o;
      OP_OR:   res = a | o;
      OP_XOR:  res = a ^ o;
      OP_CPL:  res = ~a;
      OP_CLR:  res = '0;
      OP_RL:   res = {a[DW-2:0], a[DW-1]};
      OP_RR:   res = {a[0], a[DW-1:1]};
      OP_RLC: begin
        res  = {a[DW-2:0], cy_i};
        cy_o = a[DW-1];
      end
      OP_RRC: begin
        res  = {cy_i, a[DW-1:1]};
        cy_o = a[0];
      end
      OP_SWAP: res = {a[HN-1:0], a[DW-1:HN]};
      OP_XCHD: begin
        res      = {a[DW-1:HN], o[HN-1:0]};
        opnd_res = {o[DW-1:HN], a[HN-1:0]};
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         is_div,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  logic [W-1:0]  acc_hi, acc_lo, opb;
  logic [CW-1:0] cnt;
  logic          mode_div;
  logic [W:0]    mul_sum, trial, trial_sub;
  logic          ge;

  assign mul_sum   = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, opb} : '0);
  assign trial     = {acc_hi, acc_lo[W-1]};
  assign ge        = trial >= {1'b0, opb};
  assign trial_sub = trial - {1'b0, opb};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_hi <= '0; acc_lo <= '0; opb <= '0;
      cnt <= '0; mode_div <= 1'b0; busy <= 1'b0; fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        acc_hi   <= '0;
        acc_lo   <= a;
        opb      <= b;
        mode_div <= is_div;
        cnt      <= '0;
        busy     <= 1'b1;
      end else if (busy) begin
        if (mode_div) begin
          acc_hi <= ge ? trial_sub[W-1:0] : trial[W-1:0];
          acc_lo <= {acc_lo[W-2:0], ge};
        end else begin
          acc_hi <= mul_sum[W:1];
          acc_lo <= {mul_sum[0], acc_lo[W-1:1]};
        end
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign lo = acc_lo;
  assign hi = acc_hi;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  acc_in,
  input  logic [DW-1:0]  opnd_in,
  input  logic [DW-1:0]  b_in,
  input  logic           cy_in,
  input  logic           ac_in,
  input  logic           ov_in,
  output logic [DW-1:0]  acc_out,
  output logic [DW-1:0]  opnd_out,
  output logic [DW-1:0]  b_out,
  output logic           cy_out,
  output logic           ac_out,
  output logic           ov_out,
  output logic           busy,
  output logic           done
);
  logic [DW-1:0] ar_res, lg_res, lg_opnd, md_lo, md_hi;
  logic          ar_cy, ar_ac, ar_ov, ar_hit, lg_cy, lg_hit;
  logic          md_busy, md_fin, accept, is_md;
  logic [DW-1:0] a_hold, b_hold;
  logic          ac_hold, div_hold;

  assign accept = start && !busy;
  assign is_md  = (op == OP_MUL) || (op == OP_DIV);

  acc_alu_arith u_arith (
    .op(op), .a(acc_in), .o(opnd_in), .cy_i(cy_in), .ac_i(ac_in), .ov_i(ov_in),
    .res(ar_res), .cy_o(ar_cy), .ac_o(ar_ac), .ov_o(ar_ov), .hit(ar_hit)
  );

  acc_alu_logic u_logic (
    .op(op), .a(acc_in), .o(opnd_in), .cy_i(cy_in),
    .res(lg_res), .opnd_res(lg_opnd), .cy_o(lg_cy), .hit(lg_hit)
  );

  acc_alu_muldiv #(.W(DW)) u_muldiv (
    .clk(clk), .rst(rst), .go(accept && is_md), .is_div(op == OP_DIV),
    .a(acc_in), .b(b_in), .busy(md_busy), .fin(md_fin), .lo(md_lo), .hi(md_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0; opnd_out <= '0; b_out <= '0;
      cy_out <= 1'b0; ac_out <= 1'b0; ov_out <= 1'b0;
      busy <= 1'b0; done <= 1'b0;
      a_hold <= '0; b_hold <= '0; ac_hold <= 1'b0; div_hold <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept && is_md) begin
        busy     <= 1'b1;
        a_hold   <= acc_in;
        b_hold   <= b_in;
        ac_hold  <= ac_in;
        div_hold <= (op == OP_DIV);
      end else if (accept) begin
        done     <= 1'b1;
        b_out    <= b_in;
        opnd_out <= lg_hit ? lg_opnd : opnd_in;
        if (ar_hit) begin
          acc_out <= ar_res; cy_out <= ar_cy; ac_out <= ar_ac; ov_out <= ar_ov;
        end else if (lg_hit) begin
          acc_out <= lg_res; cy_out <= lg_cy; ac_out <= ac_in; ov_out <= ov_in;
        end else begin
          acc_out <= acc_in; cy_out <= cy_in; ac_out <= ac_in; ov_out <= ov_in;
        end
      end else if (md_fin) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        cy_out <= 1'b0;
        ac_out <= ac_hold;
        if (div_hold && (b_hold == '0)) begin
          acc_out <= a_hold;
          b_out   <= b_hold;
          ov_out  <= 1'b1;
        end else begin
          acc_out <= md_lo;
          b_out   <= md_hi;
          ov_out  <= div_hold ? 1'b0 : (md_hi != '0);
        end
      end
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [OPW-1:0] op,
  input logic [W-1:0]   acc_in,
  input logic           cy_in,
  input logic [W-1:0]   acc_out,
  input logic [W-1:0]   b_out,
  input logic           cy_out,
  input logic           ov_out,
  input logic           busy,
  input logic           done
);
  localparam int LAT = W + 1;

  logic       acc_ok, md_op, md_mul;
  logic [7:0] lat_cnt;

  assign acc_ok = start && !busy;
  assign md_op  = (op == OP_MUL) || (op == OP_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt <= '0;
      md_mul  <= 1'b0;
    end else if (acc_ok && md_op) begin
      lat_cnt <= '0;
      md_mul  <= (op == OP_MUL);
    end else if (busy) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && acc_out == '0 && b_out == '0));

  // R11
  single_done_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && !md_op) |=> (done && !busy));

  // R11
  md_start_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && md_op) |=> (busy && !done));

  // R11
  busy_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R11
  md_latency_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (lat_cnt == 8'(LAT)));

  // R4
  inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && op == OP_INC) |=> (acc_out == $past(acc_in) + 1'b1 && cy_out == $past(cy_in)));

  // R9
  mul_flags_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && md_mul) |-> (!cy_out && (ov_out == (b_out != '0))));

  // R10
  div_carry_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !md_mul) |-> !cy_out);
endmodule

bind acc_alu acc_alu_chk #(.W(acc_alu_pkg::DW)) u_acc_alu_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .acc_in(acc_in), .cy_in(cy_in),
  .acc_out(acc_out), .b_out(b_out), .cy_out(cy_out), .ov_out(ov_out),
  .busy(busy), .done(done)
);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] acc_in = '0, opnd_in = '0, b_in = '0;
  logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
  logic [7:0] acc_out, opnd_out, b_out;
  logic       cy_out, ac_out, ov_out, busy, done;

  always #2 clk = ~clk;

  acc_alu dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .acc_in(acc_in),
    .opnd_in(opnd_in), .b_in(b_in), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .acc_out(acc_out), .opnd_out(opnd_out), .b_out(b_out), .cy_out(cy_out),
    .ac_out(ac_out), .ov_out(ov_out), .busy(busy), .done(done)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  // reference model state
  int m_acc = 0, m_opnd = 0, m_b = 0, m_cy = 0, m_ac = 0, m_ov = 0;
  int m_busy = 0, m_done = 0, m_cnt = 0, m_last = 0, m_in_rst = 1;
  int p_acc = 0, p_b = 0, p_ov = 0, p_ac = 0;

  function automatic string req_tag(int code);
    case (code)
      0, 1:              return "R2";
      2:                 return "R3";
      3, 4:              return "R4";
      5, 6, 7, 8, 9:     return "R5";
      10, 11, 12, 13:    return "R6";
      14, 15:            return "R7";
      16:                return "R8";
      17:                return "R9";
      18:                return "R10";
      default:           return "R12";
    endcase
  endfunction

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_acc = 0; m_opnd = 0; m_b = 0; m_cy = 0; m_ac = 0; m_ov = 0;
      m_busy = 0; m_done = 0; m_cnt = 0; m_in_rst = 1;
    end else begin
      int a, o, c, h, r, s;
      m_in_rst = 0;
      m_done = 0;
      a = int'(acc_in); o = int'(opnd_in); c = int'(cy_in); h = int'(ac_in);
      if (m_busy != 0) begin
        if (m_cnt == 1) begin
          m_busy = 0; m_done = 1;
          m_acc = p_acc; m_b = p_b; m_cy = 0; m_ov = p_ov; m_ac = p_ac;
        end else m_cnt--;
      end else if (start) begin
        m_last = int'(op);
        if (op == 5'd17 || op == 5'd18) begin
          m_busy = 1; m_cnt = 9; p_ac = h;
          if (op == 5'd17) begin
            p_acc = (a * int'(b_in)) % 256; p_b = (a * int'(b_in)) / 256;
            p_ov = (p_b != 0) ? 1 : 0;
          end else if (b_in == 8'd0) begin
            p_acc = a; p_b = 0; p_ov = 1;
          end else begin
            p_acc = a / int'(b_in); p_b = a % int'(b_in); p_ov = 0;
          end
        end else begin
          m_done = 1; m_b = int'(b_in); m_opnd = o;
          m_acc = a; m_cy = c; m_ac = h; m_ov = int'(ov_in);
          case (int'(op))
            0, 1: begin
              r = (op == 5'd1) ? c : 0;
              s = a + o + r;
              m_acc = s % 256; m_cy = (s > 255);
              m_ac = ((a % 16) + (o % 16) + r) > 15;
              s = sgn(a) + sgn(o) + r;
              m_ov = (s > 127 || s < -128);
            end
            2: begin
              s = a - o - c;
              m_acc = (s + 256) % 256; m_cy = (s < 0);
              m_ac = ((a % 16) - (o % 16) - c) < 0;
              s = sgn(a) - sgn(o) - c;
              m_ov = (s > 127 || s < -128);
            end
            3:  m_acc = (a + 1) % 256;
            4:  m_acc = (a + 255) % 256;
            5:  m_acc = a & o;
            6:  m_acc = a | o;
            7:  m_acc = a ^ o;
            8:  m_acc = 255 - a;
            9:  m_acc = 0;
            10: m_acc = ((a * 2) % 256) + (a / 128);
            11: begin m_acc = ((a * 2) % 256) + c; m_cy = a / 128; end
            12: m_acc = (a / 2) + (a % 2) * 128;
            13: begin m_acc = (a / 2) + c * 128; m_cy = a % 2; end
            14: m_acc = ((a % 16) * 16) + (a / 16);
            15: begin m_acc = (a & 8'hF0) | (o & 8'h0F); m_opnd = (o & 8'hF0) | (a & 8'h0F); end
            16: begin
              s = a;
              if ((s % 16) > 9 || h != 0) begin s += 6; if (s > 255) m_cy = 1; s %= 256; end
              if ((s / 16) > 9 || m_cy != 0) begin s += 96; if (s > 255) m_cy = 1; s %= 256; end
              m_acc = s;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      logic [29:0] act, exp;
      string tag;
      act = {acc_out, opnd_out, b_out, cy_out, ac_out, ov_out, busy, done};
      exp = {8'(m_acc), 8'(m_opnd), 8'(m_b), 1'(m_cy), 1'(m_ac), 1'(m_ov),
             1'(m_busy), 1'(m_done)};
      checks++;
      if (act !== exp) begin
        errors++;
        if (m_in_rst != 0) tag = "R1";
        else if (act[1:0] !== exp[1:0]) tag = "R11";
        else tag = req_tag(m_last);
        $display("FAIL %s op=%0d actual=%h expected=%h (acc,opnd,b,cy,ac,ov,busy,done)",
                 tag, m_last, act, exp);
      end
    end
  end

  task automatic drive(input int code, input int a, input int o, input int b,
                       input int c, input int h, input int v);
    @(negedge clk);
    op = 5'(code); acc_in = 8'(a); opnd_in = 8'(o); b_in = 8'(b);
    cy_in = 1'(c); ac_in = 1'(h); ov_in = 1'(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic issue(input int code, input int a, input int o, input int b,
                       input int c, input int h, input int v);
    drive(code, a, o, b, c, h, v);
    while (m_busy != 0) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles == 150000 && !finished) begin
      errors++; checks++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    @(posedge clk); cmp_on = 1'b1;            // R1: reset values compared here
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    issue(0, 8'h7F, 8'h01, 0, 0, 0, 0);       // R2 signed overflow, nibble carry
    issue(0, 8'hFF, 8'h01, 0, 1, 0, 0);       // R2 carry out, ADD ignores cy
    issue(1, 8'h0E, 8'h01, 0, 1, 0, 0);       // R2 add with carry
    issue(2, 8'h80, 8'h01, 0, 0, 0, 0);       // R3 overflow on borrow
    issue(2, 8'h00, 8'h00, 0, 1, 0, 0);       // R3 borrow only
    issue(3, 8'hFF, 0, 0, 1, 1, 1);           // R4 wrap up
    issue(4, 8'h00, 0, 0, 0, 1, 0);           // R4 wrap down
    issue(5, 8'hF0, 8'h3C, 0, 0, 0, 0);       // R5
    issue(6, 8'hF0, 8'h3C, 0, 1, 0, 0);
    issue(7, 8'hF0, 8'h3C, 0, 0, 1, 0);
    issue(8, 8'h5A, 0, 0, 0, 0, 1);
    issue(9, 8'h5A, 0, 0, 1, 0, 0);
    issue(10, 8'h81, 0, 0, 0, 0, 0);          // R6
    issue(11, 8'h81, 0, 0, 0, 0, 0);
    issue(12, 8'h81, 0, 0, 1, 0, 0);
    issue(13, 8'h02, 0, 0, 1, 0, 0);
    issue(14, 8'hA5, 0, 0, 0, 0, 0);          // R7
    issue(15, 8'h12, 8'h9F, 0, 0, 0, 0);
    issue(16, 8'h12, 0, 0, 0, 1, 0);          // R8 adjust from aux carry
    issue(16, 8'h99, 0, 0, 1, 0, 0);          // R8 carry forces high fix
    issue(16, 8'h9A, 0, 0, 0, 0, 0);          // R8 second step carries
    issue(17, 8'hFF, 0, 8'hFF, 1, 1, 0);      // R9
    issue(17, 8'h10, 0, 8'h02, 1, 0, 1);
    issue(18, 8'd200, 0, 8'd7, 1, 0, 1);      // R10
    issue(18, 8'h37, 0, 8'h00, 1, 1, 0);      // R10 zero divisor
    issue(18, 8'h00, 0, 8'd5, 0, 0, 1);
    drive(17, 8'd13, 0, 8'd11, 0, 0, 0);      // R11 start ignored while busy
    drive(0, 8'h44, 8'h44, 8'h66, 1, 1, 1);
    while (m_busy != 0) @(negedge clk);
    issue(25, 8'hC3, 8'h3C, 8'h77, 1, 0, 1);  // R12 unused code
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 22);
      if (r > 18) r = 19 + $urandom_range(0, 12);
      issue(r, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
            $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end
    repeat (3) @(negedge clk);
    summary();
  end
endmodule